// File: doc/BRIEF.md
# Four-way key merge unit

This block merges up to four key-ordered record streams into one ordered output stream, as the inner step of a compaction job. Each lane hands over one record at a time (key, key length, record length, value and an end-of-lane marker) through a valid/ready pair. A task begins with a one-cycle `start` and a lane mask. A lane buffer holds one record per lane. Once every live lane holds a record, only the keys are copied into a key buffer. A comparison stage picks the smallest key. The controller then forwards the whole winning record from its lane buffer to the output. Values are never copied into the comparison path.

If several lanes hold the same key, the record from the lowest-numbered lane is sent and the copies in the other lanes are discarded, so only the newest version survives. A lane leaves the merge once its marked final record has been consumed. When no live lane remains, the task ends with a one-cycle `done` and a return code. If any buffered record is longer than the configured limit, the task stops at once with a failure code, and the host must then redo that task by other means.

Top module: `keymerge4`

## Requirements
- R1: Only lanes whose bit is set in `lane_mask` at `start` take part: a lane outside the mask never sees `in_ready` high during that task, and its records never appear at the output.
- R2: Output keys come out in strictly ascending order. Keys are unsigned big-endian byte strings with byte 0 in `in_key[127:120]` of the lane slice, and only the first `klen` bytes count (bytes past `klen` are treated as zero). When two keys have equal padded bytes, the shorter one comes first, so a prefix sorts before any longer key that starts with it.
- R3: When several live lanes hold the same key and the same key length, exactly one record is emitted, the one from the lowest-numbered lane, and the equal records in the other lanes are consumed without output.
- R4: Each output carries the winning record complete: its key (masked to `klen`), `klen`, record length, value and source lane number in `out_lane`.
- R5: A lane whose record with `in_last` set has been consumed drops out. The task ends once all masked lanes have dropped out, after emitting every surviving record.
- R6: `done` is high for exactly one cycle. On a successful task it rises in the cycle after the final output record is accepted (`out_valid` and `out_ready` both high), and `status` then reads 2'b01.
- R7: If a buffered record has a length above `MAX_REC_LEN`, the task aborts. `done` pulses with `status` 2'b10, no further record is emitted, and the next task starts clean.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all output record fields hold steady.
- R9: During and right after reset, `out_valid`, `done` and every `in_ready` bit are low and `status` reads 2'b00.
- R10: Between tasks no lane is ready and nothing is emitted. A task started with an all-zero mask finishes with `status` 2'b01 and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a task; honoured only when idle |
| lane_mask | input | NUM_LANES | Lanes taking part in the task |
| in_valid | input | NUM_LANES | Per-lane record valid |
| in_ready | output | NUM_LANES | Per-lane record accepted |
| in_last | input | NUM_LANES | Record is the lane's final one |
| in_key | input | NUM_LANES*KEY_BYTES*8 | Per-lane key, big-endian, left aligned |
| in_klen | input | NUM_LANES*KLEN_W | Per-lane key length in bytes |
| in_len | input | NUM_LANES*LEN_W | Per-lane whole record length |
| in_value | input | NUM_LANES*VAL_W | Per-lane value payload |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream accepts output record |
| out_key | output | KEY_BYTES*8 | Winning key, masked to its length |
| out_klen | output | KLEN_W | Winning key length |
| out_len | output | LEN_W | Winning record length |
| out_value | output | VAL_W | Winning value |
| out_lane | output | LANE_W | Lane the record came from |
| done | output | 1 | One-cycle task-end pulse |
| status | output | 2 | Return code: 01 success, 10 failure |

## Verification
On every cycle, the assertions check that each accepted key is strictly greater than the previous one in the task, that the output holds under stall, that `done` lasts a single cycle and arrives with nothing ready or valid, and that no lane outside the task's mask is ever ready. The bench scenarios show what a per-cycle check cannot. They show which lane wins a tie and that its copies vanish, that a prefix orders before its extensions, that the exact record set and count come out, that `done` lands one cycle after the last handshake, and that an oversized record gives the failure code with no output and no damage to the next task.

// File: rtl/keymerge4_pkg.sv
// Shared types for the four-way key merge unit.
// Assumes: consumers import this package; encodings are fixed by the port contract.
package keymerge4_pkg;

    // Task return code seen on the status port
    typedef enum logic [1:0] {
        RC_NONE = 2'b00,
        RC_OK   = 2'b01,
        RC_FAIL = 2'b10
    } keymerge4_rc_e;

    // Controller phases: gather records, stage keys, compare, hand out winner
    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_LOAD,
        S_CMP,
        S_EMIT
    } keymerge4_state_e;

endpackage

// File: rtl/keymerge4_lane_buf.sv
// One-entry holding register for a single input lane.
// Holds the whole record (key, lengths, value, final marker) until the controller
// pops it. Assumes pop is only raised while the entry is full and that clr wins
// over everything else.
module keymerge4_lane_buf #(
    parameter int KEY_W  = 128,
    parameter int KLEN_W = 5,
    parameter int LEN_W  = 8,
    parameter int VAL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic              push_last,
    input  logic [KEY_W-1:0]  push_key,
    input  logic [KLEN_W-1:0] push_klen,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [VAL_W-1:0]  push_value,
    input  logic              pop,
    output logic              full,
    output logic              last,
    output logic [KEY_W-1:0]  key,
    output logic [KLEN_W-1:0] klen,
    output logic [LEN_W-1:0]  len,
    output logic [VAL_W-1:0]  value
);

    // Accept only for a live lane with a free slot
    assign push_ready = en && !full;

    // Occupancy flag of the single slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (clr || pop)
            full <= 1'b0;
        else if (push_valid && push_ready)
            full <= 1'b1;
    end

    // Record capture on a handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last  <= 1'b0;
            key   <= '0;
            klen  <= '0;
            len   <= '0;
            value <= '0;
        end else if (push_valid && push_ready) begin
            last  <= push_last;
            key   <= push_key;
            klen  <= push_klen;
            len   <= push_len;
            value <= push_value;
        end
    end

endmodule

// File: rtl/keymerge4_key_stage.sv
// Key buffer: copies only the keys of the selected lanes, with every byte past
// the key length forced to zero, so that later stages can order keys as plain
// unsigned numbers. Assumes byte 0 of a key sits in its top eight bits.
module keymerge4_key_stage #(
    parameter int NUM_LANES = 4,
    parameter int KEY_BYTES = 16,
    parameter int KLEN_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_LANES-1:0]          sel,
    input  logic [NUM_LANES*KEY_BYTES*8-1:0] lane_key,
    input  logic [NUM_LANES*KLEN_W-1:0]   lane_klen,
    output logic [NUM_LANES-1:0]          buf_vld,
    output logic [NUM_LANES*KEY_BYTES*8-1:0] buf_key,
    output logic [NUM_LANES*KLEN_W-1:0]   buf_klen
);

    localparam int KEY_W = KEY_BYTES * 8;

    logic [NUM_LANES*KEY_W-1:0] masked;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
        // Zero every byte at or beyond this lane's key length
        always_comb begin
            for (int b = 0; b < KEY_BYTES; b++) begin
                if (KLEN_W'(b) < lane_klen[g*KLEN_W +: KLEN_W])
                    masked[g*KEY_W + (KEY_BYTES-1-b)*8 +: 8] =
                        lane_key[g*KEY_W + (KEY_BYTES-1-b)*8 +: 8];
                else
                    masked[g*KEY_W + (KEY_BYTES-1-b)*8 +: 8] = 8'h00;
            end
        end
    end

    // Occupancy of the key slots, refreshed on every load
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_vld <= '0;
        else if (load)
            buf_vld <= sel;
    end

    // Key and length capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_key  <= '0;
            buf_klen <= '0;
        end else if (load) begin
            buf_key  <= masked;
            buf_klen <= lane_klen;
        end
    end

endmodule

// File: rtl/keymerge4_cmp_pe.sv
// Comparison engine: finds the smallest staged key and every lane holding a
// copy of it. The order key is {masked key, key length} read as one unsigned
// number, which gives byte-wise order with a prefix first. A strict less-than
// scan keeps the lowest lane on ties. Purely combinational; assumes keys masked.
module keymerge4_cmp_pe #(
    parameter int NUM_LANES = 4,
    parameter int KEY_W     = 128,
    parameter int KLEN_W    = 5,
    parameter int LANE_W    = 2
) (
    input  logic [NUM_LANES-1:0]        vld,
    input  logic [NUM_LANES*KEY_W-1:0]  key,
    input  logic [NUM_LANES*KLEN_W-1:0] klen,
    output logic [LANE_W-1:0]           win,
    output logic [NUM_LANES-1:0]        dup
);

    localparam int ORD_W = KEY_W + KLEN_W;

    logic [ORD_W-1:0] best;
    logic             found;

    // Minimum search with lowest-lane preference, then copy detection
    always_comb begin
        found = 1'b0;
        best  = '0;
        win   = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (vld[i] && (!found ||
                {key[i*KEY_W +: KEY_W], klen[i*KLEN_W +: KLEN_W]} < best)) begin
                found = 1'b1;
                best  = {key[i*KEY_W +: KEY_W], klen[i*KLEN_W +: KLEN_W]};
                win   = LANE_W'(i);
            end
        end
        for (int i = 0; i < NUM_LANES; i++)
            dup[i] = found && vld[i] &&
                     ({key[i*KEY_W +: KEY_W], klen[i*KLEN_W +: KLEN_W]} == best);
    end

endmodule

// File: rtl/keymerge4.sv
// Four-way key merge unit, top level.
// A controller steps FILL -> LOAD -> CMP -> EMIT per output record: wait until
// every live lane buffer is full, stage the keys, register the comparison, then
// offer the winner and pop it together with its equal copies. Oversized records
// abort the task. Assumes each lane delivers its records in ascending key order,
// at least one record per masked lane, and that start is only raised when idle.
module keymerge4
    import keymerge4_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int KEY_BYTES   = 16,
    parameter int VAL_W       = 32,
    parameter int LEN_W       = 8,
    parameter int MAX_REC_LEN = 64,
    localparam int KEY_W      = KEY_BYTES * 8,
    localparam int KLEN_W     = $clog2(KEY_BYTES + 1),
    localparam int LANE_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_LANES-1:0]        lane_mask,
    input  logic [NUM_LANES-1:0]        in_valid,
    output logic [NUM_LANES-1:0]        in_ready,
    input  logic [NUM_LANES-1:0]        in_last,
    input  logic [NUM_LANES*KEY_W-1:0]  in_key,
    input  logic [NUM_LANES*KLEN_W-1:0] in_klen,
    input  logic [NUM_LANES*LEN_W-1:0]  in_len,
    input  logic [NUM_LANES*VAL_W-1:0]  in_value,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [KEY_W-1:0]            out_key,
    output logic [KLEN_W-1:0]           out_klen,
    output logic [LEN_W-1:0]            out_len,
    output logic [VAL_W-1:0]            out_value,
    output logic [LANE_W-1:0]           out_lane,
    output logic                        done,
    output logic [1:0]                  status
);

    keymerge4_state_e state;
    keymerge4_rc_e    status_q;

    logic [NUM_LANES-1:0] live;
    logic [NUM_LANES-1:0] drop_q;
    logic [LANE_W-1:0]    win_q;
    logic                 done_q;

    logic [NUM_LANES-1:0]        lb_full, lb_last, lb_pop;
    logic [NUM_LANES*KEY_W-1:0]  lb_key;
    logic [NUM_LANES*KLEN_W-1:0] lb_klen;
    logic [NUM_LANES*LEN_W-1:0]  lb_len;
    logic [NUM_LANES*VAL_W-1:0]  lb_value;

    logic [NUM_LANES-1:0]        kb_vld;
    logic [NUM_LANES*KEY_W-1:0]  kb_key;
    logic [NUM_LANES*KLEN_W-1:0] kb_klen;

    logic [LANE_W-1:0]    pe_win;
    logic [NUM_LANES-1:0] pe_dup;

    logic                 over_any;
    logic                 all_ready;
    logic                 abort;
    logic                 accept;
    logic [NUM_LANES-1:0] live_after;

    // Lane buffers, one per input lane
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        keymerge4_lane_buf #(
            .KEY_W (KEY_W),
            .KLEN_W(KLEN_W),
            .LEN_W (LEN_W),
            .VAL_W (VAL_W)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (abort),
            .en        (live[g] && (state != S_IDLE)),
            .push_valid(in_valid[g]),
            .push_ready(in_ready[g]),
            .push_last (in_last[g]),
            .push_key  (in_key[g*KEY_W +: KEY_W]),
            .push_klen (in_klen[g*KLEN_W +: KLEN_W]),
            .push_len  (in_len[g*LEN_W +: LEN_W]),
            .push_value(in_value[g*VAL_W +: VAL_W]),
            .pop       (lb_pop[g]),
            .full      (lb_full[g]),
            .last      (lb_last[g]),
            .key       (lb_key[g*KEY_W +: KEY_W]),
            .klen      (lb_klen[g*KLEN_W +: KLEN_W]),
            .len       (lb_len[g*LEN_W +: LEN_W]),
            .value     (lb_value[g*VAL_W +: VAL_W])
        );
    end

    keymerge4_key_stage #(
        .NUM_LANES(NUM_LANES),
        .KEY_BYTES(KEY_BYTES),
        .KLEN_W   (KLEN_W)
    ) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == S_LOAD),
        .sel      (live & lb_full),
        .lane_key (lb_key),
        .lane_klen(lb_klen),
        .buf_vld  (kb_vld),
        .buf_key  (kb_key),
        .buf_klen (kb_klen)
    );

    keymerge4_cmp_pe #(
        .NUM_LANES(NUM_LANES),
        .KEY_W    (KEY_W),
        .KLEN_W   (KLEN_W),
        .LANE_W   (LANE_W)
    ) u_pe (
        .vld (kb_vld),
        .key (kb_key),
        .klen(kb_klen),
        .win (pe_win),
        .dup (pe_dup)
    );

    // Length limit check over every occupied lane buffer
    always_comb begin
        over_any = 1'b0;
        for (int i = 0; i < NUM_LANES; i++)
            if (lb_full[i] && (lb_len[i*LEN_W +: LEN_W] > LEN_W'(MAX_REC_LEN)))
                over_any = 1'b1;
    end

    // Handshake, pop and drop-out decisions of the current cycle
    always_comb begin
        all_ready  = &(~live | lb_full);
        abort      = (state == S_FILL) && over_any;
        accept     = (state == S_EMIT) && out_ready;
        lb_pop     = accept ? drop_q : '0;
        live_after = live & ~(drop_q & lb_last);
    end

    // Task sequencing, winner capture and return code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            live     <= '0;
            win_q    <= '0;
            drop_q   <= '0;
            done_q   <= 1'b0;
            status_q <= RC_NONE;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        live  <= lane_mask;
                        state <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (over_any) begin
                        live     <= '0;
                        done_q   <= 1'b1;
                        status_q <= RC_FAIL;
                        state    <= S_IDLE;
                    end else if (live == '0) begin
                        done_q   <= 1'b1;
                        status_q <= RC_OK;
                        state    <= S_IDLE;
                    end else if (all_ready) begin
                        state <= S_LOAD;
                    end
                end
                S_LOAD: state <= S_CMP;
                S_CMP: begin
                    win_q  <= pe_win;
                    drop_q <= pe_dup;
                    state  <= S_EMIT;
                end
                S_EMIT: begin
                    if (out_ready) begin
                        live <= live_after;
                        if (live_after == '0) begin
                            done_q   <= 1'b1;
                            status_q <= RC_OK;
                            state    <= S_IDLE;
                        end else begin
                            state <= S_FILL;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output record: key from the key buffer, the rest from the lane buffer
    assign out_valid = (state == S_EMIT);
    assign out_key   = kb_key[win_q*KEY_W +: KEY_W];
    assign out_klen  = kb_klen[win_q*KLEN_W +: KLEN_W];
    assign out_len   = lb_len[win_q*LEN_W +: LEN_W];
    assign out_value = lb_value[win_q*VAL_W +: VAL_W];
    assign out_lane  = win_q;
    assign done      = done_q;
    assign status    = status_q;

endmodule

// File: rtl/keymerge4_chk.sv
// Property checker for keymerge4, attached by bind below.
// Keeps its own copy of the task mask and of the last accepted key.
module keymerge4_chk #(
    parameter int NUM_LANES = 4,
    parameter int KEY_W     = 128,
    parameter int KLEN_W    = 5,
    parameter int LEN_W     = 8,
    parameter int VAL_W     = 32,
    parameter int LANE_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [NUM_LANES-1:0] lane_mask,
    input logic [NUM_LANES-1:0] in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [KEY_W-1:0]     out_key,
    input logic [KLEN_W-1:0]    out_klen,
    input logic [LEN_W-1:0]     out_len,
    input logic [VAL_W-1:0]     out_value,
    input logic [LANE_W-1:0]    out_lane,
    input logic                 done
);

    logic [NUM_LANES-1:0]    mask_q;
    logic                    have_prev;
    logic [KEY_W+KLEN_W-1:0] prev_ord;

    // Observer state: task mask and last accepted order key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            have_prev <= 1'b0;
            prev_ord  <= '0;
        end else begin
            if (start) begin
                mask_q    <= lane_mask;
                have_prev <= 1'b0;
            end else if (out_valid && out_ready) begin
                have_prev <= 1'b1;
                prev_ord  <= {out_key, out_klen};
            end
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !done && (in_ready == '0)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key) &&
        $stable(out_klen) && $stable(out_len) && $stable(out_value) &&
        $stable(out_lane)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && (in_ready == '0)));

    // R2
    key_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && have_prev) |-> ({out_key, out_klen} > prev_ord));

    // R1
    mask_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~mask_q) == '0);

endmodule

bind keymerge4 keymerge4_chk #(
    .NUM_LANES(NUM_LANES),
    .KEY_W    (KEY_W),
    .KLEN_W   (KLEN_W),
    .LEN_W    (LEN_W),
    .VAL_W    (VAL_W),
    .LANE_W   (LANE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .lane_mask(lane_mask),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_key  (out_key),
    .out_klen (out_klen),
    .out_len  (out_len),
    .out_value(out_value),
    .out_lane (out_lane),
    .done     (done)
);

// File: tb/keymerge4_tb.sv
// Self-checking bench for keymerge4: a table of merge tasks walked by one loop,
// then directed reset, idle and abort checks.
// Record descriptor: [15:8] key byte 0, [7:4] low nibble of key byte 1, [3:0] key length.
module keymerge4_tb;

    localparam int NL = 4;
    localparam int KB = 16;
    localparam int KW = KB * 8;
    localparam int KLW = 5;
    localparam int LW = 8;
    localparam int VW = 32;
    localparam int NC = 6;

    localparam logic [15:0] CREC [NC][4][3] = '{
        '{'{16'h1002, 16'h4002, 16'h7002}, '{16'h2002, 16'h5002, 16'h0000},
          '{16'h3002, 16'h0000, 16'h0000}, '{16'h0502, 16'h6002, 16'h9002}},
        '{'{16'h2002, 16'h3002, 16'h0000}, '{16'h2002, 16'h4002, 16'h0000},
          '{16'h3002, 16'h4002, 16'h0000}, '{16'h2002, 16'h0000, 16'h0000}},
        '{'{16'h5003, 16'h0000, 16'h0000}, '{16'h5001, 16'h0000, 16'h0000},
          '{16'h5002, 16'h0000, 16'h0000}, '{16'h0101, 16'h0000, 16'h0000}},
        '{'{16'h0101, 16'h0102, 16'h0000}, '{16'h1102, 16'h2202, 16'h3302},
          '{16'h0000, 16'h0000, 16'h0000}, '{16'h1122, 16'h2203, 16'h4002}},
        '{'{16'h7702, 16'h8802, 16'h0000}, '{16'h0000, 16'h0000, 16'h0000},
          '{16'h0000, 16'h0000, 16'h0000}, '{16'h0000, 16'h0000, 16'h0000}},
        '{'{16'h0000, 16'h0000, 16'h0000}, '{16'h0000, 16'h0000, 16'h0000},
          '{16'h0000, 16'h0000, 16'h0000}, '{16'h0000, 16'h0000, 16'h0000}}
    };
    localparam int CCNT [NC][4] = '{'{3,2,1,3}, '{2,2,2,1}, '{1,1,1,1},
                                    '{2,3,0,3}, '{2,0,0,0}, '{0,0,0,0}};
    localparam logic [3:0] CMASK [NC] = '{4'hF, 4'hF, 4'h7, 4'hA, 4'h1, 4'h0};
    localparam int CEXP [NC] = '{9, 3, 3, 6, 2, 0};
    localparam int CBP  [NC] = '{0, 1, 0, 1, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NL-1:0] lane_mask = '0;
    logic [NL-1:0] in_valid = '0;
    logic [NL-1:0] in_ready;
    logic [NL-1:0] in_last = '0;
    logic [NL*KW-1:0] in_key = '0;
    logic [NL*KLW-1:0] in_klen = '0;
    logic [NL*LW-1:0] in_len = '0;
    logic [NL*VW-1:0] in_value = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [KW-1:0] out_key;
    logic [KLW-1:0] out_klen;
    logic [LW-1:0] out_len;
    logic [VW-1:0] out_value;
    logic [1:0] out_lane;
    logic done;
    logic [1:0] status;

    int total = 0;
    int bad = 0;

    logic [15:0] desc [4][3];
    int cnt [4];
    int ptr [4];
    logic [3:0] mask;
    int bad_lane = -1;
    int bad_idx = 0;
    int exp_lane [16];
    int exp_idx [16];
    int exp_n;

    always #2 clk = ~clk;

    keymerge4 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_mask(lane_mask),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_key(in_key), .in_klen(in_klen), .in_len(in_len), .in_value(in_value),
        .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
        .out_klen(out_klen), .out_len(out_len), .out_value(out_value),
        .out_lane(out_lane), .done(done), .status(status)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [191:0] act, input logic [191:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [KW-1:0] mk_key(input logic [15:0] d);
        logic [KW-1:0] k;
        k = '0;
        k[KW-1 -: 8] = d[15:8];
        if (d[3:0] >= 4'd2) k[KW-9 -: 8] = {4'h0, d[7:4]};
        return k;
    endfunction

    function automatic logic [KW+KLW-1:0] ord(input logic [15:0] d);
        return {mk_key(d), 1'b0, d[3:0]};
    endfunction

    function automatic logic [LW-1:0] mk_len(input int l, input int k);
        if (l == bad_lane && k == bad_idx) return 8'd100;
        return 8'(desc[l][k][3:0]) + 8'd4;
    endfunction

    function automatic logic [VW-1:0] mk_val(input int l, input int k);
        return {16'hC0DE, 8'(l), 8'(k)};
    endfunction

    // Reference merge: smallest key first, lowest lane on ties, copies dropped
    task automatic build_expect();
        int h [4];
        int best;
        for (int l = 0; l < 4; l++) h[l] = 0;
        exp_n = 0;
        if (bad_lane >= 0) return;
        forever begin
            best = -1;
            for (int l = 0; l < 4; l++)
                if (mask[l] && h[l] < cnt[l])
                    if (best < 0 || ord(desc[l][h[l]]) < ord(desc[best][h[best]]))
                        best = l;
            if (best < 0) break;
            exp_lane[exp_n] = best;
            exp_idx[exp_n] = h[best];
            exp_n++;
            for (int l = 0; l < 4; l++)
                if (l != best && mask[l] && h[l] < cnt[l] &&
                    ord(desc[l][h[l]]) == ord(desc[best][h[best]]))
                    h[l]++;
            h[best]++;
        end
    endtask

    task automatic drive_lanes();
        for (int l = 0; l < 4; l++) begin
            in_valid[l] = (ptr[l] < cnt[l]);
            in_last[l] = (ptr[l] == cnt[l] - 1);
            if (ptr[l] < cnt[l]) begin
                in_key[l*KW +: KW] = mk_key(desc[l][ptr[l]]);
                in_klen[l*KLW +: KLW] = 5'(desc[l][ptr[l]][3:0]);
                in_len[l*LW +: LW] = mk_len(l, ptr[l]);
                in_value[l*VW +: VW] = mk_val(l, ptr[l]);
            end
        end
    endtask

    task automatic run_job(input int c);
        int got;
        logic acc_last;
        logic seen;
        logic stall_pend;
        logic [KW-1:0] stall_key;
        logic [191:0] a, e;
        int el, ei;
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 3; k++) desc[l][k] = CREC[c][l][k];
            cnt[l] = CCNT[c][l];
            ptr[l] = 0;
        end
        mask = CMASK[c];
        build_expect();
        @(negedge clk);
        start = 1'b1;
        lane_mask = mask;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        acc_last = 1'b0;
        seen = 1'b0;
        stall_pend = 1'b0;
        for (int cyc = 0; cyc < 3000 && !seen; cyc++) begin
            drive_lanes();
            out_ready = (CBP[c] != 0) ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (stall_pend)
                chk(out_valid && out_key == stall_key, "R8 held under stall",
                    {63'd0, out_valid, out_key}, {63'd0, 1'b1, stall_key});
            stall_pend = out_valid && !out_ready;
            stall_key = out_key;
            if (done) begin
                seen = 1'b1;
                chk(got == ((bad_lane >= 0) ? 0 : CEXP[c]), "R5 record count",
                    192'(got), 192'((bad_lane >= 0) ? 0 : CEXP[c]));
                if (bad_lane >= 0)
                    chk(status == 2'b10, "R7 abort code", 192'(status), 192'(2'b10));
                else
                    chk(status == 2'b01, "R6 success code", 192'(status), 192'(2'b01));
                if (exp_n > 0)
                    chk(acc_last, "R6 done one cycle after final accept",
                        192'(acc_last), 192'(1));
            end else begin
                for (int l = 0; l < 4; l++)
                    if (in_valid[l] && in_ready[l]) ptr[l]++;
                acc_last = 1'b0;
                if (out_valid && out_ready) begin
                    if (got < exp_n) begin
                        el = exp_lane[got];
                        ei = exp_idx[got];
                        a = {out_lane, out_klen, out_len, out_value, out_key};
                        e = {2'(el), 5'(desc[el][ei][3:0]), mk_len(el, ei),
                             mk_val(el, ei), mk_key(desc[el][ei])};
                        chk(a == e, "R2 R3 R4 merged record", a, e);
                    end else begin
                        chk(1'b0, "R2 R7 unexpected record", {64'd0, out_key}, 192'd0);
                    end
                    got++;
                    acc_last = (got == exp_n);
                end
                @(negedge clk);
            end
        end
        if (!seen) chk(1'b0, "R5 watchdog on task end", 192'(0), 192'(1));
        in_valid = '0;
        @(negedge clk);
        #1;
        chk(!done, "R6 done lasts one cycle", 192'(done), 192'(0));
        for (int l = 0; l < 4; l++)
            if (!mask[l])
                chk(ptr[l] == 0, "R1 unmasked lane untouched", 192'(ptr[l]), 192'(0));
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !done && in_ready == '0 && status == 2'b00, "R9 reset state",
            {187'd0, out_valid, done, in_ready == '0, status},
            {187'd0, 1'b0, 1'b0, 1'b1, 2'b00});
        @(negedge clk);
        rst_n = 1'b1;
        // Idle: lanes offer records but none is taken
        in_valid = '1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(in_ready == '0 && !out_valid, "R10 idle takes nothing",
                {187'd0, in_ready, out_valid}, 192'd0);
        end
        in_valid = '0;
        for (int c = 0; c < NC; c++) run_job(c);
        // Oversized record aborts, then a normal task runs clean
        bad_lane = 2;
        bad_idx = 0;
        run_job(0);
        bad_lane = -1;
        run_job(1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule